// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer between two unrelated clock domains. Words enter on the write clock and leave on the read clock. A write is taken on a write-clock edge with the write enable high. A read is taken on a read-clock edge with the read enable high. Each side has its own full or empty indication, which errs on the safe side. The write and read positions cross between the domains as Gray code through a chain of synchroniser flops.

Two active-low level flags warn before the buffer fills or drains. They compare the stored word count with two offsets that can be loaded. The first offset sets how far below the capacity the almost-full warning begins. The second sets the count at or below which the almost-empty warning shows. Two straps are sampled while reset is held:
- The read-mode strap picks standard reads, where data appears one read-clock edge after an accepted read, or first-word-fall-through, where the oldest word waits on the output already. In fall-through mode the output register adds one word of capacity.
- The flag-timing strap picks synchronous flags, each computed in a single domain, or asynchronous flags. An asynchronous flag is raised by the clock whose traffic moves the count toward the threshold and lowered by the other clock.

Top module: `dcfifo_pflag`

## Requirements
- R1: Words leave in the order they were accepted, in both read modes and under any interleaving of the two clocks.
- R2: `full` is high when the storage array holds DEPTH words. A write while `full` is high is dropped and overwrites nothing.
- R3: After reset `empty` is high. In standard mode a read while `empty` is high is dropped and leaves `rd_data` unchanged.
- R4: In standard mode (`rd_mode_sel` low at reset), `rd_data` shows the oldest word after the read-clock edge that accepts a read.
- R5: In fall-through mode (`rd_mode_sel` high at reset), the oldest word appears on `rd_data` with no read request, and `empty` low means that word is valid. A read consumes it. The total capacity is DEPTH+1, so `full` is still low at DEPTH words and high at DEPTH+1 once the output register is loaded.
- R6: `afull_n` is 0 when the count C satisfies C + m >= DEPTH + f, and 1 otherwise. Here m is the almost-full offset and f is 1 in fall-through mode and 0 in standard mode.
- R7: `aempty_n` is 0 when C <= n + f and 1 otherwise, where n is the almost-empty offset.
- R8: With `flag_timing_sel` low at reset (asynchronous flags), both flags follow the true count. `afull_n` falls right after the write-clock edge of the write that crosses its threshold, and rises right after the read-clock edge of a read, even while the other clock is stopped. `aempty_n` behaves the same way with the roles of the clocks reversed.
- R9: With `flag_timing_sel` high at reset (synchronous flags), `afull_n` changes only on write-clock edges and `aempty_n` only on read-clock edges. Each reflects traffic from the other domain only after that domain's position has been synchronised. With the storage array empty in standard mode, `aempty_n` is 0.
- R10: `rd_mode_sel` and `flag_timing_sel` are sampled only while `rst_n` is low. Changing them afterwards has no effect.
- R11: During reset the offsets take the values DEF_AF_OFS and DEF_AE_OFS (default 2 each). A write-clock edge with `ofs_ld` high loads `af_ofs_in` and `ae_ofs_in`.
- R12: After reset `full` is 0, `afull_n` is 1 and `aempty_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock, unrelated to wclk |
| rst_n | input | 1 | Master reset, active low. Both clocks must run while it is low |
| rd_mode_sel | input | 1 | Strap sampled in reset: 0 standard reads, 1 first-word-fall-through |
| flag_timing_sel | input | 1 | Strap sampled in reset: 0 asynchronous flag timing, 1 synchronous |
| wr_en | input | 1 | Write request, sampled on wclk |
| wr_data | input | DW | Write word |
| full | output | 1 | Storage full, write-clock domain |
| rd_en | input | 1 | Read request, sampled on rclk |
| rd_data | output | DW | Read word |
| empty | output | 1 | No word available, read-clock domain |
| ofs_ld | input | 1 | Loads both offsets on a wclk edge |
| af_ofs_in | input | AW+1 | New almost-full offset m |
| ae_ofs_in | input | AW+1 | New almost-empty offset n |
| afull_n | output | 1 | Almost-full warning, active low |
| aempty_n | output | 1 | Almost-empty warning, active low |

## Verification
The assertions check invariants that must hold at every edge. These are: a write while full or a standard read while empty moves no pointer, occupancy never passes DEPTH, and the Gray write position changes at most one bit per step. They also check that a loaded fall-through output holds while no read is requested, and that a synchronous almost-empty flag is low whenever standard storage is empty. Other behaviour needs whole scenarios. This covers exact flag thresholds at each count with either offset set, and which clock moves each flag in each timing mode, which the bench shows by stopping one clock at a time. It also covers the extra fall-through word of capacity and the fact that straps changed after reset have no effect.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

   localparam int GMAX = 32;

   typedef enum logic {RD_STANDARD = 1'b0, RD_FALLTHRU = 1'b1} rd_mode_e;

   function automatic logic [GMAX-1:0] to_gray(input logic [GMAX-1:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [GMAX-1:0] from_gray(input logic [GMAX-1:0] g);
      logic [GMAX-1:0] b;
      b = g;
      for (int s = 1; s < GMAX; s = s << 1) b = b ^ (b >> s);
      return b;
   endfunction

endpackage

// File: rtl/dcf_gray_xing.sv
// Carries a Gray-coded position into another clock domain and decodes it.
module dcf_gray_xing #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] gray_in,
   output logic [W-1:0] bin_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dcf_gray_xing: STAGES must be at least 2");
   end
   if (W > dcf_pkg::GMAX) begin : g_bad_width
      $error("dcf_gray_xing: W exceeds GMAX");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg[0] <= gray_in;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign bin_out = W'(dcf_pkg::from_gray(32'(stg[STAGES-1])));
endmodule

// File: rtl/dcf_ram.sv
// Storage array: one write port on wclk, combinational read.
module dcf_ram #(
   parameter int DW = 36,
   parameter int AW = 4
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int WORDS = 1 << AW;

   logic [DW-1:0] mem [WORDS];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_level_cmp.sv
// Threshold compare for one level flag; HIGH_SIDE picks the variant.
module dcf_level_cmp #(
   parameter int PW        = 5,
   parameter int DEPTH     = 16,
   parameter bit HIGH_SIDE = 1'b1
) (
   input  logic [PW-1:0] level,
   input  logic [PW-1:0] ofs,
   input  logic          extra,
   output logic          flag_n
);
   localparam int CW = PW + 2;

   logic [CW-1:0] lhs, rhs;

   if (HIGH_SIDE) begin : g_high
      assign lhs    = CW'(level) + CW'(ofs);
      assign rhs    = CW'(DEPTH) + CW'(extra);
      assign flag_n = !(lhs >= rhs);
   end else begin : g_low
      assign lhs    = CW'(level);
      assign rhs    = CW'(ofs) + CW'(extra);
      assign flag_n = !(lhs <= rhs);
   end
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
   parameter int DW          = 36,
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int DEF_AF_OFS  = 2,
   parameter int DEF_AE_OFS  = 2,
   localparam int AW         = $clog2(DEPTH),
   localparam int PW         = AW + 1
) (
   input  logic          wclk,
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          rd_mode_sel,
   input  logic          flag_timing_sel,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   output logic          full,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic          empty,
   input  logic          ofs_ld,
   input  logic [PW-1:0] af_ofs_in,
   input  logic [PW-1:0] ae_ofs_in,
   output logic          afull_n,
   output logic          aempty_n
);
   import dcf_pkg::*;

   if ((DEPTH < 4) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("dcfifo_pflag: DEPTH must be a power of two, at least 4");
   end
   if (DW < 1) begin : g_bad_dw
      $error("dcfifo_pflag: DW must be positive");
   end
   if ((DEF_AF_OFS < 0) || (DEF_AF_OFS > DEPTH) ||
       (DEF_AE_OFS < 0) || (DEF_AE_OFS > DEPTH)) begin : g_bad_ofs
      $error("dcfifo_pflag: default offsets must lie in 0..DEPTH");
   end

   localparam logic [PW-1:0] FULL_XOR = {1'b1, {AW{1'b0}}};

   // ---------------- write domain ----------------
   logic [PW-1:0] wbin, wgray, wbin_nx;
   logic [PW-1:0] rbin_w, ubin_w;
   logic [PW-1:0] af_ofs, ae_ofs;
   logic          fwft_w, async_w;
   logic          wr_go;

   always_ff @(posedge wclk) begin
      if (!rst_n) begin
         fwft_w  <= rd_mode_sel;
         async_w <= !flag_timing_sel;
      end
   end

   always_ff @(posedge wclk) begin
      if (!rst_n) begin
         af_ofs <= PW'(DEF_AF_OFS);
         ae_ofs <= PW'(DEF_AE_OFS);
      end else if (ofs_ld) begin
         af_ofs <= af_ofs_in;
         ae_ofs <= ae_ofs_in;
      end
   end

   assign full    = ((wbin ^ rbin_w) == FULL_XOR);
   assign wr_go   = wr_en && !full;
   assign wbin_nx = wbin + 1'b1;

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (wr_go) begin
         wbin  <= wbin_nx;
         wgray <= PW'(to_gray(32'(wbin_nx)));
      end
   end

   // ---------------- read domain ----------------
   logic [PW-1:0] rbin, rgray, rbin_nx;
   logic [PW-1:0] ubin, ugray, ubin_nx;
   logic [PW-1:0] wbin_r;
   logic          fwft_r, async_r;
   logic          ov, ram_empty, rd_go, fetch;
   logic [DW-1:0] ram_q;

   always_ff @(posedge rclk) begin
      if (!rst_n) begin
         fwft_r  <= rd_mode_sel;
         async_r <= !flag_timing_sel;
      end
   end

   assign ram_empty = (wbin_r == rbin);
   assign rbin_nx   = rbin + 1'b1;
   assign ubin_nx   = ubin + 1'b1;

   always_comb begin
      if (rd_mode_e'(fwft_r) == RD_FALLTHRU) begin
         rd_go = rd_en && ov;
         fetch = !ram_empty && (!ov || rd_go);
         empty = !ov;
      end else begin
         rd_go = rd_en && !ram_empty;
         fetch = rd_go;
         empty = ram_empty;
      end
   end

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rbin    <= '0;
         rgray   <= '0;
         ubin    <= '0;
         ugray   <= '0;
         ov      <= 1'b0;
         rd_data <= '0;
      end else begin
         if (fetch) begin
            rbin    <= rbin_nx;
            rgray   <= PW'(to_gray(32'(rbin_nx)));
            rd_data <= ram_q;
         end
         if (rd_go) begin
            ubin  <= ubin_nx;
            ugray <= PW'(to_gray(32'(ubin_nx)));
         end
         if (!fwft_r)    ov <= 1'b0;
         else if (fetch) ov <= 1'b1;
         else if (rd_go) ov <= 1'b0;
      end
   end

   // ---------------- storage and crossings ----------------
   dcf_ram #(.DW(DW), .AW(AW)) u_ram (
      .wclk (wclk),
      .we   (wr_go),
      .waddr(wbin[AW-1:0]),
      .wdata(wr_data),
      .raddr(rbin[AW-1:0]),
      .rdata(ram_q)
   );

   dcf_gray_xing #(.W(PW), .STAGES(SYNC_STAGES)) u_wpos_to_r (
      .clk(rclk), .rst_n(rst_n), .gray_in(wgray), .bin_out(wbin_r)
   );
   dcf_gray_xing #(.W(PW), .STAGES(SYNC_STAGES)) u_rpos_to_w (
      .clk(wclk), .rst_n(rst_n), .gray_in(rgray), .bin_out(rbin_w)
   );
   dcf_gray_xing #(.W(PW), .STAGES(SYNC_STAGES)) u_upos_to_w (
      .clk(wclk), .rst_n(rst_n), .gray_in(ugray), .bin_out(ubin_w)
   );

   // ---------------- level flags ----------------
   // Asynchronous timing compares live positions from both domains;
   // synchronous timing uses only positions held in the flag's own domain.
   logic [PW-1:0] lvl_w, lvl_r;

   assign lvl_w = async_w ? (wbin - ubin)   : (wbin - ubin_w);
   assign lvl_r = async_r ? (wbin - ubin)   : (wbin_r - ubin);

   dcf_level_cmp #(.PW(PW), .DEPTH(DEPTH), .HIGH_SIDE(1'b1)) u_af_cmp (
      .level(lvl_w), .ofs(af_ofs), .extra(fwft_w), .flag_n(afull_n)
   );
   dcf_level_cmp #(.PW(PW), .DEPTH(DEPTH), .HIGH_SIDE(1'b0)) u_ae_cmp (
      .level(lvl_r), .ofs(ae_ofs), .extra(fwft_r), .flag_n(aempty_n)
   );
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
   parameter int DW    = 36,
   parameter int PW    = 5,
   parameter int DEPTH = 16
) (
   input logic          wclk,
   input logic          rclk,
   input logic          rst_n,
   input logic          wr_en,
   input logic          rd_en,
   input logic          full,
   input logic          empty,
   input logic          aempty_n,
   input logic [DW-1:0] rd_data,
   input logic [PW-1:0] wbin,
   input logic [PW-1:0] wgray,
   input logic [PW-1:0] rbin,
   input logic [PW-1:0] rbin_w,
   input logic          fwft_r,
   input logic          async_r
);
   logic [PW-1:0] occ_w;
   assign occ_w = wbin - rbin_w;

   a_r2_full_blocks_write: assert property (
      @(posedge wclk) disable iff (!rst_n)
      (wr_en && full) |=> $stable(wbin))
      else $error("R2: write position moved while full");

   a_r2_occupancy_bound: assert property (
      @(posedge wclk) disable iff (!rst_n)
      occ_w <= PW'(DEPTH))
      else $error("R2: occupancy above depth");

   a_r3_empty_blocks_read: assert property (
      @(posedge rclk) disable iff (!rst_n)
      (!fwft_r && rd_en && empty) |=> $stable(rbin))
      else $error("R3: read position moved while empty");

   a_r5_fallthru_output_hold: assert property (
      @(posedge rclk) disable iff (!rst_n)
      (fwft_r && !empty && !rd_en) |=> $stable(rd_data))
      else $error("R5: presented word changed without a read");

   a_r9_sync_empty_warns: assert property (
      @(posedge rclk) disable iff (!rst_n)
      (!async_r && !fwft_r && empty) |-> !aempty_n)
      else $error("R9: almost-empty high with storage empty");

   a_r1_gray_one_bit: assert property (
      @(posedge wclk) disable iff (!rst_n)
      $countones(wgray ^ $past(wgray)) <= 1)
      else $error("R1: Gray write position changed more than one bit");
endmodule

bind dcfifo_pflag dcf_checker #(.DW(DW), .PW(PW), .DEPTH(DEPTH)) u_chk (
   .wclk    (wclk),
   .rclk    (rclk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .rd_en   (rd_en),
   .full    (full),
   .empty   (empty),
   .aempty_n(aempty_n),
   .rd_data (rd_data),
   .wbin    (wbin),
   .wgray   (wgray),
   .rbin    (rbin),
   .rbin_w  (rbin_w),
   .fwft_r  (fwft_r),
   .async_r (async_r)
);

// File: tb/dcfifo_pflag_test.sv
module dcfifo_pflag_test;
   localparam int DW    = 36;
   localparam int DEPTH = 16;
   localparam int PW    = 5;
   localparam int M0    = 2;
   localparam int N0    = 2;

   logic wraw = 1'b0, rraw = 1'b0, wrun = 1'b1, rrun = 1'b1;
   logic wclk, rclk;
   always #10 wraw = ~wraw;   // 50 MHz write clock
   always #17 rraw = ~rraw;   // unrelated read clock
   assign wclk = wraw & wrun;
   assign rclk = rraw & rrun;

   logic          rst_n = 1'b0, rd_mode_sel = 1'b0, flag_timing_sel = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0, ofs_ld = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [PW-1:0] af_ofs_in = '0, ae_ofs_in = '0;
   logic          full, empty, afull_n, aempty_n;
   logic [DW-1:0] rd_data;

   dcfifo_pflag #(.DW(DW), .DEPTH(DEPTH), .DEF_AF_OFS(M0), .DEF_AE_OFS(N0)) uut (
      .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .rd_mode_sel(rd_mode_sel),
      .flag_timing_sel(flag_timing_sel), .wr_en(wr_en), .wr_data(wr_data),
      .full(full), .rd_en(rd_en), .rd_data(rd_data), .empty(empty),
      .ofs_ld(ofs_ld), .af_ofs_in(af_ofs_in), .ae_ofs_in(ae_ofs_in),
      .afull_n(afull_n), .aempty_n(aempty_n)
   );

   int            total = 0, bad = 0;
   logic [DW-1:0] q[$];
   int            m_ofs = M0, n_ofs = N0, fw = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit exp_af_n(input int c);
      return !((c + m_ofs) >= (DEPTH + fw));
   endfunction
   function automatic bit exp_ae_n(input int c);
      return !(c <= (n_ofs + fw));
   endfunction

   task automatic chk_flags(input string req);
      int c = q.size();
      chk(afull_n == exp_af_n(c), {"R6 ", req}, afull_n, exp_af_n(c));
      chk(aempty_n == exp_ae_n(c), {"R7 ", req}, aempty_n, exp_ae_n(c));
   endtask

   task automatic wgate(input bit on);
      @(negedge wraw); wrun = on;
   endtask
   task automatic rgate(input bit on);
      @(negedge rraw); rrun = on;
   endtask

   task automatic do_reset(input bit f, input bit async_timing);
      rst_n = 1'b0; rd_mode_sel = f; flag_timing_sel = !async_timing;
      wr_en = 1'b0; rd_en = 1'b0; ofs_ld = 1'b0;
      wgate(1); rgate(1);
      repeat (4) @(negedge wraw);
      repeat (4) @(negedge rraw);
      rst_n = 1'b1;
      fw = f; m_ofs = M0; n_ofs = N0;
      q.delete();
      repeat (2) @(negedge wraw);
   endtask

   task automatic load_ofs(input int m, input int n);
      @(negedge wclk); ofs_ld = 1'b1; af_ofs_in = PW'(m); ae_ofs_in = PW'(n);
      @(negedge wclk); ofs_ld = 1'b0;
      m_ofs = m; n_ofs = n;
   endtask

   task automatic wr_word(input logic [DW-1:0] d);
      bit ok;
      @(negedge wclk); ok = !full; wr_en = 1'b1; wr_data = d;
      @(negedge wclk); wr_en = 1'b0;
      if (ok) q.push_back(d);
   endtask

   task automatic rd_word(input string req);
      bit ok;
      logic [DW-1:0] prev;
      @(negedge rclk); ok = !empty; prev = rd_data;
      if (fw != 0 && ok) chk(q.size() > 0 && rd_data == q[0], {"R5 R1 ", req}, rd_data, q.size() > 0 ? q[0] : '0);
      rd_en = 1'b1;
      @(negedge rclk); rd_en = 1'b0;
      if (ok) begin
         if (fw == 0) chk(q.size() > 0 && rd_data == q[0], {"R4 R1 ", req}, rd_data, q.size() > 0 ? q[0] : '0);
         if (q.size() > 0) void'(q.pop_front());
      end else if (fw == 0) begin
         chk(rd_data == prev, "R3 dropped read keeps output", rd_data, prev);
      end
   endtask

   task automatic settle();
      repeat (8) @(negedge wraw);
      repeat (8) @(negedge rraw);
   endtask

   task automatic settle_chk(input string req);
      settle();
      chk(full == (q.size() == DEPTH + fw), {"R2 R5 ", req}, full, q.size() == DEPTH + fw);
      chk(empty == (q.size() == 0), {"R3 ", req}, empty, q.size() == 0);
      chk_flags(req);
   endtask

   task automatic drain(input string req);
      for (int g = 0; g < 200 && q.size() > 0; g++) rd_word(req);
      settle_chk({req, " drained"});
   endtask

   task automatic traffic(input int n, input int wpct, input int rpct);
      fork
         begin
            for (int i = 0; i < n; i++)
               if (($urandom % 100) < wpct) wr_word(DW'({$urandom(), $urandom()}));
               else @(negedge wclk);
         end
         begin
            for (int i = 0; i < n; i++)
               if (($urandom % 100) < rpct) rd_word("random");
               else @(negedge rclk);
         end
      join
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      #(20 * 190000);
      total++; bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));

      // ---- standard reads, asynchronous flags ----
      do_reset(1'b0, 1'b1);
      chk(empty == 1'b1, "R12 R3 empty after reset", empty, 1);
      chk(full == 1'b0, "R12 full after reset", full, 0);
      chk(afull_n == 1'b1, "R12 afull_n after reset", afull_n, 1);
      chk(aempty_n == 1'b0, "R12 aempty_n after reset", aempty_n, 0);

      rgate(0);
      flag_timing_sel = 1'b1;   // R10: strap change after reset must not matter
      rd_mode_sel     = 1'b1;
      for (int k = 1; k <= DEPTH; k++) begin
         wr_word(DW'(k * 32'h1111));
         chk_flags("R8 R10 R11 fill, read clock stopped");
      end
      chk(full == 1'b1, "R2 full at depth", full, 1);
      wr_word(DW'(36'hBADBADBAD));
      chk(full == 1'b1 && afull_n == 1'b0, "R2 write while full dropped", {full, afull_n}, 2'b10);
      rgate(1);
      wgate(0);
      repeat (4) @(negedge rclk);
      for (int g = 0; g < 60 && q.size() > 0; g++) begin
         rd_word("R8 drain, write clock stopped");
         chk_flags("R8 R10 drain, write clock stopped");
      end
      chk(empty == 1'b1, "R3 empty after drain", empty, 1);
      rd_word("R3 read while empty");
      wgate(1);

      // offsets reload, thresholds move
      load_ofs(5, 4);
      rgate(0);
      for (int k = 0; k < 12; k++) begin
         wr_word(DW'(k + 36'h100));
         chk_flags("R11 loaded offsets");
      end
      rgate(1);
      repeat (4) @(negedge rclk);
      drain("R11 std async");
      traffic(400, 75, 45);
      settle_chk("R1 std async fill");
      traffic(400, 35, 80);
      drain("R1 std async");

      // ---- standard reads, synchronous flags ----
      do_reset(1'b0, 1'b0);
      rgate(0);
      for (int k = 0; k < DEPTH - 1; k++) begin
         wr_word(DW'(k + 36'h200));
         chk(afull_n == exp_af_n(q.size()), "R9 R6 write-side flag on wclk", afull_n, exp_af_n(q.size()));
         chk(aempty_n == 1'b0, "R9 almost-empty waits for read clock", aempty_n, 0);
      end
      rgate(1);
      repeat (6) @(negedge rclk);
      chk(aempty_n == 1'b1, "R9 almost-empty released by read clock", aempty_n, 1);
      wgate(0);
      repeat (3) rd_word("R9 partial drain");
      chk(afull_n == 1'b0, "R9 almost-full held while write clock stopped", afull_n, 0);
      wgate(1);
      repeat (6) @(negedge wclk);
      chk(afull_n == 1'b1, "R9 almost-full released by write clock", afull_n, 1);
      drain("R9 std sync");
      traffic(400, 80, 40);
      settle_chk("R1 R9 std sync fill");
      traffic(400, 30, 80);
      drain("R1 R9 std sync");

      // ---- fall-through reads, asynchronous flags ----
      do_reset(1'b1, 1'b1);
      rgate(0);
      for (int k = 0; k < 4; k++) begin
         wr_word(DW'(k + 36'h300));
         chk_flags("R8 R5 fall-through fill");
      end
      chk(empty == 1'b1, "R5 no word shown before read clock runs", empty, 1);
      rgate(1);
      repeat (4) @(negedge rclk);
      chk(empty == 1'b0, "R5 word falls through", empty, 0);
      chk(rd_data == q[0], "R5 oldest word presented", rd_data, q[0]);
      while (q.size() < DEPTH + 1) begin
         wr_word(DW'(q.size() + 36'h400));
         chk_flags("R8 R5 fall-through fill, no reads");
         if (q.size() == DEPTH) begin
            settle();
            chk(full == 1'b0, "R5 room for one more at depth", full, 0);
         end
      end
      settle_chk("R5 capacity depth plus one");
      wgate(0);
      for (int g = 0; g < 60 && q.size() > 0; g++) begin
         rd_word("R5 drain");
         chk_flags("R8 R5 fall-through drain, write clock stopped");
      end
      wgate(1);
      traffic(400, 75, 45);
      settle_chk("R1 R5 fall-through async fill");
      traffic(400, 35, 80);
      drain("R1 R5 fall-through async");

      // ---- fall-through reads, synchronous flags ----
      do_reset(1'b1, 1'b0);
      load_ofs(3, 5);
      traffic(400, 80, 40);
      settle_chk("R1 R9 fall-through sync fill");
      traffic(400, 30, 80);
      drain("R1 R9 fall-through sync");

      summary();
      $finish;
   end
endmodule